// File: doc/BRIEF.md
# Vector Bitwise Select Unit

This block carries out the two bitwise-select operations of a 128-bit vector pipeline. It decodes the instruction word. It takes the register values the read stage has already fetched, and it returns the destination index, the new 128-bit value and a write strobe. The register file sits outside the block.

The register form chooses every result bit from one of two data vectors, steered by a third vector used as a mask. The immediate form has no separate mask operand. It uses the current contents of the destination register as the mask and chooses between one source vector and an 8-bit constant copied into every byte lane. For that reason the read stage must supply the old destination value for this form.

Results appear one clock after the input is presented. Any instruction word that matches neither form raises an illegal flag and leaves the write strobe low.

Top module: `vbsel_unit`

## Requirements
- R1: A valid word whose bits 31:20 equal 12'h0D1 is the register form. One cycle later `outWe` is 1, `outIllegal` is 0 and `outDestIdx` equals bits 4:0 of that word.
- R2: In the register form, each result bit equals the matching bit of `srcK` where `srcMask` holds 1, and the matching bit of `srcJ` where it holds 0. This applies to all 128 bits.
- R3: A valid word whose bits 31:18 equal 14'h1CF1 is the immediate form. Its 8-bit constant is taken from bits 17:10. One cycle later `outWe` is 1, `outIllegal` is 0 and `outDestIdx` equals bits 4:0.
- R4: In the immediate form, each result bit is chosen by the matching bit of `oldDest`. Where that bit is 1, the result takes bit (n mod 8) of the constant. Where it is 0, the result takes the bit of `srcJ`. The constant is repeated in all 16 bytes.
- R5: All outputs are registered. They change only at the clock edge after the input, so driving new inputs leaves the outputs unchanged until that edge.
- R6: A valid word that matches neither form gives `outIllegal`=1 and `outWe`=0 one cycle later. `outData` keeps its previous value.
- R7: A cycle with `inValid`=0 gives `outWe`=0 and `outIllegal`=0 one cycle later, and `outData` is unchanged.
- R8: While `rstN` is low, `outWe`, `outIllegal`, `outDestIdx` and `outData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| srcJ | input | 128 | First data source value |
| srcK | input | 128 | Second data source value (register form) |
| srcMask | input | 128 | Mask vector value (register form) |
| oldDest | input | 128 | Current destination value, used as the mask by the immediate form |
| outDestIdx | output | 5 | Destination register index |
| outData | output | 128 | Result vector |
| outWe | output | 1 | Write enable for the result |
| outIllegal | output | 1 | The instruction word matched neither form |

## Verification
The hardest case to reach is a near-miss encoding that differs from a legal opcode in a single bit. Examples are the two bits just above the immediate field, or the lowest opcode bit of the register form. Random words almost never land there, so the bench builds these words on purpose, directly after legal writes. It then confirms that the earlier result stays on `outData`. For the immediate form, the bench uses the constants 0x00, 0xFF and 0xA5 with random and all-ones destination masks. This separates constant bits from source bits in every lane.

// File: rtl/vbsel_pkg.sv
package vbsel_pkg;
  localparam int VLEN = 128;
  localparam int LANEW = 8;
  localparam int LANES = VLEN / LANEW;
  localparam int IDXW = 5;
  localparam int IMMW = 8;

  localparam logic [11:0] OPC_REG = 12'h0D1;
  localparam logic [13:0] OPC_IMM = 14'h1CF1;

  typedef struct packed {
    logic load;
    logic useImm;
    logic flagIllegal;
    logic [IDXW-1:0] destIdx;
    logic [IMMW-1:0] imm;
  } ctrlStrobes_t;
endpackage

// File: rtl/vbsel_ctrl.sv
module vbsel_ctrl
  import vbsel_pkg::*;
(
  input  logic inValid,
  input  logic [31:0] instr,
  output ctrlStrobes_t strobes
);
  logic isReg;
  logic isImm;

  assign isReg = (instr[31:20] == OPC_REG);
  assign isImm = (instr[31:18] == OPC_IMM);

  always_comb begin
    strobes.load        = inValid && (isReg || isImm);
    strobes.useImm      = isImm;
    strobes.flagIllegal = inValid && !isReg && !isImm;
    strobes.destIdx     = instr[IDXW-1:0];
    strobes.imm         = instr[17:10];
  end
endmodule

// File: rtl/vbsel_dp.sv
module vbsel_dp
  import vbsel_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  ctrlStrobes_t strobes,
  input  logic [VLEN-1:0] srcJ,
  input  logic [VLEN-1:0] srcK,
  input  logic [VLEN-1:0] srcMask,
  input  logic [VLEN-1:0] oldDest,
  output logic [IDXW-1:0] outDestIdx,
  output logic [VLEN-1:0] outData,
  output logic outWe,
  output logic outIllegal
);
  logic [VLEN-1:0] selMask;
  logic [VLEN-1:0] selOne;
  logic [VLEN-1:0] nextData;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    localparam int LO = lane * LANEW;
    always_comb begin
      if (strobes.useImm) begin
        selMask[LO +: LANEW] = oldDest[LO +: LANEW];
        selOne[LO +: LANEW]  = strobes.imm;
      end else begin
        selMask[LO +: LANEW] = srcMask[LO +: LANEW];
        selOne[LO +: LANEW]  = srcK[LO +: LANEW];
      end
    end
  end

  assign nextData = (selMask & selOne) | (~selMask & srcJ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outDestIdx <= '0;
      outData    <= '0;
      outWe      <= 1'b0;
      outIllegal <= 1'b0;
    end else begin
      outWe      <= strobes.load;
      outIllegal <= strobes.flagIllegal;
      if (strobes.load) begin
        outDestIdx <= strobes.destIdx;
        outData    <= nextData;
      end
    end
  end
endmodule

// File: rtl/vbsel_unit.sv
module vbsel_unit
  import vbsel_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic [31:0] instr,
  input  logic [VLEN-1:0] srcJ,
  input  logic [VLEN-1:0] srcK,
  input  logic [VLEN-1:0] srcMask,
  input  logic [VLEN-1:0] oldDest,
  output logic [IDXW-1:0] outDestIdx,
  output logic [VLEN-1:0] outData,
  output logic outWe,
  output logic outIllegal
);
  ctrlStrobes_t strobes;

  vbsel_ctrl i_ctrl (
    .inValid(inValid),
    .instr(instr),
    .strobes(strobes)
  );

  vbsel_dp i_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .srcJ(srcJ),
    .srcK(srcK),
    .srcMask(srcMask),
    .oldDest(oldDest),
    .outDestIdx(outDestIdx),
    .outData(outData),
    .outWe(outWe),
    .outIllegal(outIllegal)
  );
endmodule

// File: rtl/vbsel_checker.sv
module vbsel_checker
  import vbsel_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic [31:0] instr,
  input logic [VLEN-1:0] srcJ,
  input logic [VLEN-1:0] srcK,
  input logic [VLEN-1:0] srcMask,
  input logic [VLEN-1:0] oldDest,
  input logic [IDXW-1:0] outDestIdx,
  input logic [VLEN-1:0] outData,
  input logic outWe,
  input logic outIllegal
);
  logic regHit;
  logic immHit;
  assign regHit = inValid && (instr[31:20] == 12'h0D1);
  assign immHit = inValid && (instr[31:18] == 14'h1CF1);

  AST_REG_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    regHit |=> outWe && !outIllegal && outDestIdx == $past(instr[4:0])); // R1
  AST_REG_DATA: assert property (@(posedge clk) disable iff (!rstN)
    regHit |=> outData == (($past(srcMask) & $past(srcK)) | (~$past(srcMask) & $past(srcJ)))); // R2
  AST_IMM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    immHit |=> outWe && !outIllegal && outDestIdx == $past(instr[4:0])); // R3
  AST_IMM_DATA: assert property (@(posedge clk) disable iff (!rstN)
    immHit |=> outData == (($past(oldDest) & {LANES{$past(instr[17:10])}})
                          | (~$past(oldDest) & $past(srcJ)))); // R4
  AST_BAD_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !regHit && !immHit) |=> outIllegal && !outWe && $stable(outData)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outWe && !outIllegal && $stable(outData)); // R7
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(outWe && outIllegal)); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> !outWe && !outIllegal && outData == '0 && outDestIdx == '0); // R8
endmodule

bind vbsel_unit vbsel_checker i_vbsel_checker (.*);

// File: tb/test_vbsel_unit.sv
`timescale 1ns/1ps
module test_vbsel_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [127:0] srcJ = '0, srcK = '0, srcMask = '0, oldDest = '0;
  logic [4:0] outDestIdx;
  logic [127:0] outData;
  logic outWe, outIllegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [4:0] expIdx = '0;
  logic [127:0] expData = '0;
  logic expWe = 1'b0;
  logic expIll = 1'b0;

  always #5 clk = ~clk;

  vbsel_unit i_vbsel_unit (.*);

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [31:0] mkReg(logic [4:0] vd, logic [4:0] vj, logic [4:0] vk, logic [4:0] va);
    return {12'h0D1, va, vk, vj, vd};
  endfunction

  function automatic logic [31:0] mkImm(logic [4:0] vd, logic [4:0] vj, logic [7:0] imm);
    return {14'h1CF1, imm, vj, vd};
  endfunction

  task automatic compare(string tag);
    checks++;
    if (outWe !== expWe || outIllegal !== expIll || outData !== expData ||
        (expWe && outDestIdx !== expIdx)) begin
      errors++;
      $display("FAIL %s: we=%b ill=%b idx=%0d data=%h expected we=%b ill=%b idx=%0d data=%h",
               tag, outWe, outIllegal, outDestIdx, outData, expWe, expIll, expIdx, expData);
    end
  endtask

  task automatic step(logic v, logic [31:0] w, logic [127:0] j, logic [127:0] k,
                      logic [127:0] m, logic [127:0] d, string tag);
    logic isReg, isImm;
    logic [127:0] res;
    inValid = v; instr = w; srcJ = j; srcK = k; srcMask = m; oldDest = d;
    #1 compare("R5 outputs held before edge");
    isReg = (w[31:20] == 12'h0D1);
    isImm = (w[31:18] == 14'h1CF1);
    res = '0;
    for (int b = 0; b < 128; b++) begin
      if (isImm) res[b] = d[b] ? w[10 + (b % 8)] : j[b];
      else       res[b] = m[b] ? k[b] : j[b];
    end
    expWe = v && (isReg || isImm);
    expIll = v && !isReg && !isImm;
    if (expWe) begin
      expData = res;
      expIdx = w[4:0];
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] imms[3];
    imms[0] = 8'h00; imms[1] = 8'hFF; imms[2] = 8'hA5;
    repeat (3) @(negedge clk);
    compare("R8 reset state");
    rstN = 1'b1;
    @(negedge clk);
    compare("R8 after release");

    // R1 R2: register form, random and corner masks
    for (int i = 0; i < 40; i++)
      step(1, mkReg(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom)),
           rnd128(), rnd128(), rnd128(), rnd128(), "R1 R2 register select");
    step(1, mkReg(5'd31, 5'd1, 5'd2, 5'd3), rnd128(), rnd128(), '1, rnd128(), "R2 mask all ones");
    step(1, mkReg(5'd0, 5'd1, 5'd2, 5'd3), rnd128(), rnd128(), '0, rnd128(), "R2 mask all zeros");

    // R3 R4: immediate form with fixed constants
    for (int c = 0; c < 3; c++) begin
      for (int i = 0; i < 12; i++)
        step(1, mkImm(5'($urandom), 5'($urandom), imms[c]),
             rnd128(), rnd128(), rnd128(), rnd128(), "R3 R4 immediate select");
      step(1, mkImm(5'd7, 5'd8, imms[c]), rnd128(), rnd128(), rnd128(), '1, "R4 dest all ones");
      step(1, mkImm(5'd9, 5'd8, imms[c]), rnd128(), rnd128(), rnd128(), '0, "R4 dest all zeros");
    end

    // R6: near-miss encodings right after a legal write
    step(1, mkImm(5'd3, 5'd4, 8'h5A), rnd128(), rnd128(), rnd128(), rnd128(), "R3 setup");
    step(1, mkImm(5'd3, 5'd4, 8'h5A) ^ 32'h0004_0000, rnd128(), rnd128(), rnd128(), rnd128(), "R6 imm bit18 flip");
    step(1, mkImm(5'd3, 5'd4, 8'h5A) ^ 32'h0008_0000, rnd128(), rnd128(), rnd128(), rnd128(), "R6 imm bit19 flip");
    step(1, mkReg(5'd6, 5'd1, 5'd2, 5'd3) ^ 32'h0010_0000, rnd128(), rnd128(), rnd128(), rnd128(), "R6 reg bit20 flip");
    step(1, mkReg(5'd6, 5'd1, 5'd2, 5'd3) ^ 32'h8000_0000, rnd128(), rnd128(), rnd128(), rnd128(), "R6 reg bit31 flip");
    for (int i = 0; i < 10; i++)
      step(1, $urandom, rnd128(), rnd128(), rnd128(), rnd128(), "R6 random word");

    // R7: idle cycles with legal-looking words on the bus
    step(0, mkReg(5'd1, 5'd2, 5'd3, 5'd4), rnd128(), rnd128(), rnd128(), rnd128(), "R7 idle reg word");
    step(0, mkImm(5'd1, 5'd2, 8'hFF), rnd128(), rnd128(), rnd128(), rnd128(), "R7 idle imm word");
    step(0, 32'h0, rnd128(), rnd128(), rnd128(), rnd128(), "R7 idle zero");
    step(1, mkReg(5'd12, 5'd2, 5'd3, 5'd4), rnd128(), rnd128(), rnd128(), rnd128(), "R1 after idle");

    // R8: reset in mid-stream
    rstN = 1'b0;
    expWe = 0; expIll = 0; expData = '0; expIdx = '0;
    #1 compare("R8 async reset");
    @(negedge clk);
    rstN = 1'b1;
    step(1, mkImm(5'd2, 5'd3, 8'hA5), rnd128(), rnd128(), rnd128(), rnd128(), "R4 after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule